// File: doc/BRIEF.md
# DRAM Power-Up and Self-Refresh Sequencer

This block owns the row and column strobes of an asynchronous x16 DRAM while the memory is not being read or written. It runs from a single fixed-frequency clock. After reset it waits out the mandatory power-up pause. It then issues a burst of column-before-row wake-up cycles and raises a done flag. From then on it serves two kinds of host request: single refresh cycles, and self-refresh sessions with an entry request and an exit request.

Every interval is counted in clock cycles. The limits given in nanoseconds or microseconds are converted at elaboration from the clock period, rounding up. The one exception is the early column-strobe release at self-refresh exit, which rounds down because it is a maximum. A refresh request, or a request to enter self-refresh, that cannot be served at once is remembered and served later. A request to enter self-refresh that arrives before the wake-up burst has finished is dropped. An exit request is held until the minimum row-low time of the session has run out.

Top module: `dram_init_sref_seq`

## Requirements
- R1: While reset is asserted, both strobes are high (inactive), busy is 1 and init_done is 0.
- R2: After reset is released, neither strobe goes low during the first PAUSE_CYC = ceil(PAUSE_NS / CLK_NS) cycles. The column strobe falls in cycle PAUSE_CYC.
- R3: After the pause, exactly INIT_CYCLES (at least 8) column-before-row cycles are issued. init_done rises when the last of them ends and stays high until reset.
- R4: In every refresh-type cycle the column strobe is low alone for CSR_CYC cycles. Both strobes are then low for RAS_CYC cycles, and both are high for RP_CYC cycles afterwards.
- R5: busy is 1 from reset until init_done, during every refresh cycle and during a whole self-refresh session. It is 0 in idle, and both strobes are high whenever busy is 0.
- R6: A refresh request made during the wake-up burst or during self-refresh is held. It is served as one refresh cycle once the block is idle again.
- R7: A self-refresh entry request is dropped if it arrives before init_done, or while a self-refresh session is already in progress.
- R8: Self-refresh entry drops the column strobe CSR_CYC cycles before the row strobe. The row strobe then stays low for at least SRAS_CYC = ceil(SREF_RAS_NS / CLK_NS) cycles.
- R9: An exit request made before SRAS_CYC has run out is held and acted on when it runs out. Without an exit request the session lasts indefinitely. An exit request made outside self-refresh is ignored.
- R10: On exit, the column strobe rises exactly LEAD_CYC = floor(CAS_EARLY_NS / CLK_NS) cycles before the row strobe. A session with an early exit request therefore keeps the row strobe low for SRAS_CYC + LEAD_CYC cycles.
- R11: After the row strobe rises at exit, both strobes stay high for at least SRPS_CYC = ceil(SREF_PRE_NS / CLK_NS) cycles before the next cycle begins.
- R12: When a refresh request and a self-refresh entry request are both pending in idle, the refresh cycle is issued first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, fixed frequency of period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | Request one refresh cycle (latched) |
| sref_enter | input | 1 | Request entry into self-refresh (latched when allowed) |
| sref_exit | input | 1 | Request exit from self-refresh (latched only in a session) |
| row_strobe_n | output | 1 | Active-low row address strobe to the DRAM |
| col_strobe_n | output | 1 | Active-low column address strobe to the DRAM |
| busy | output | 1 | High while the sequencer owns the strobes |
| init_done | output | 1 | High once the power-up burst has completed |

## Verification
The embedded properties assume that all three request inputs are synchronous to clk. They also assume that reset is held for at least one clock edge, so that the quiet-pause counter and the run-length counters start from a known point. The properties place no limit on how long a request stays high, because every request goes through a set-dominant latch. The stimulus still drives each request as a pulse of exactly one cycle, changed on the falling clock edge. It places the pulses deliberately: during the pause, at the first row-low cycle of a session, in idle, and several thousand cycles into a session. In this way every latch is used once in its accepting window and once in its ignoring window.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [3:0] {
      ST_PAUSE,
      ST_CBR_CAS,
      ST_CBR_RAS,
      ST_CBR_PRE,
      ST_IDLE,
      ST_SR_CAS,
      ST_SR_HOLD,
      ST_SR_WAIT,
      ST_SR_LEAD,
      ST_SR_PRE
   } seq_state_t;

   typedef struct packed {
      logic row_n;
      logic col_n;
      logic busy;
   } pins_t;

   // minimum intervals: round up so the limit is never undercut
   function automatic int unsigned cyc_ceil(input int unsigned t_ns, input int unsigned clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction

   // maximum intervals: round down so the limit is never exceeded
   function automatic int unsigned cyc_floor(input int unsigned t_ns, input int unsigned clk_ns);
      return t_ns / clk_ns;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic pins_t pins_of(input seq_state_t s);
      pins_t p;
      case (s)
         ST_CBR_CAS, ST_SR_CAS:  p = '{row_n: 1'b1, col_n: 1'b0, busy: 1'b1};
         ST_CBR_RAS, ST_SR_HOLD,
         ST_SR_WAIT:             p = '{row_n: 1'b0, col_n: 1'b0, busy: 1'b1};
         ST_SR_LEAD:             p = '{row_n: 1'b0, col_n: 1'b1, busy: 1'b1};
         ST_IDLE:                p = '{row_n: 1'b1, col_n: 1'b1, busy: 1'b0};
         default:                p = '{row_n: 1'b1, col_n: 1'b1, busy: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
   parameter int unsigned W       = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   if (W < 1 || W > 31) begin : g_bad_width
      $error("seq_timer: W out of range");
   end
   if (RST_VAL >= (32'd1 << W)) begin : g_bad_rst
      $error("seq_timer: RST_VAL does not fit in W bits");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/req_latch.sv
module req_latch #(
   parameter bit CLEAR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic accept,
   input  logic clr,
   output logic pending
);

   logic take;
   assign take = set & accept;

   if (CLEAR_WINS) begin : g_clear_wins
      always_ff @(posedge clk) begin
         if (!rst_n)   pending <= 1'b0;
         else if (clr) pending <= 1'b0;
         else          pending <= pending | take;
      end
   end else begin : g_set_wins
      always_ff @(posedge clk) begin
         if (!rst_n) pending <= 1'b0;
         else        pending <= (pending & ~clr) | take;
      end
   end

endmodule

// File: rtl/wake_counter.sv
module wake_counter #(
   parameter int unsigned N = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic last,
   output logic done
);

   localparam int unsigned CW = $clog2(N + 1);

   if (N < 1) begin : g_bad_n
      $error("wake_counter: N must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (tick && !done) begin
         cnt <= cnt + 1'b1;
         if (last) done <= 1'b1;
      end
   end

   // R3: once complete, the flag never drops
   p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

endmodule

// File: rtl/dram_init_sref_seq.sv
module dram_init_sref_seq
   import dram_seq_pkg::*;
#(
   parameter int unsigned CLK_NS       = 20,
   parameter int unsigned PAUSE_NS     = 200_000,
   parameter int unsigned SREF_RAS_NS  = 100_000,
   parameter int unsigned SREF_PRE_NS  = 90,
   parameter int unsigned CAS_EARLY_NS = 50,
   parameter int unsigned INIT_CYCLES  = 8,
   parameter int unsigned CSR_CYC      = 1,
   parameter int unsigned RAS_CYC      = 4,
   parameter int unsigned RP_CYC       = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_req,
   input  logic sref_enter,
   input  logic sref_exit,
   output logic row_strobe_n,
   output logic col_strobe_n,
   output logic busy,
   output logic init_done
);

   localparam int unsigned PAUSE_CYC = cyc_ceil(PAUSE_NS, CLK_NS);
   localparam int unsigned SRAS_CYC  = cyc_ceil(SREF_RAS_NS, CLK_NS);
   localparam int unsigned SRPS_CYC  = cyc_ceil(SREF_PRE_NS, CLK_NS);
   localparam int unsigned LEAD_CYC  = cyc_floor(CAS_EARLY_NS, CLK_NS);
   localparam int unsigned MAX_LOAD  = max_u(max_u(PAUSE_CYC, SRAS_CYC),
                                            max_u(max_u(SRPS_CYC, LEAD_CYC),
                                                  max_u(max_u(CSR_CYC, RAS_CYC), RP_CYC)));
   localparam int unsigned TW        = $clog2(MAX_LOAD + 1);

   localparam logic [TW-1:0] LD_CSR  = TW'(CSR_CYC - 1);
   localparam logic [TW-1:0] LD_RAS  = TW'(RAS_CYC - 1);
   localparam logic [TW-1:0] LD_RP   = TW'(RP_CYC - 1);
   localparam logic [TW-1:0] LD_SRAS = TW'(SRAS_CYC - 1);
   localparam logic [TW-1:0] LD_SRPS = TW'(SRPS_CYC - 1);
   localparam logic [TW-1:0] LD_LEAD = TW'((LEAD_CYC == 0) ? 0 : LEAD_CYC - 1);

   // elaboration checks on the parameter set
   if (CLK_NS == 0) begin : g_bad_clk
      $error("dram_init_sref_seq: CLK_NS must be nonzero");
   end
   if (INIT_CYCLES < 8) begin : g_bad_init
      $error("dram_init_sref_seq: at least eight wake-up cycles are required");
   end
   if (CSR_CYC < 1 || RAS_CYC < 1 || RP_CYC < 1) begin : g_bad_cbr
      $error("dram_init_sref_seq: refresh cycle phases need at least one cycle");
   end
   if (PAUSE_CYC < 1 || SRAS_CYC <= RAS_CYC || SRPS_CYC < 1) begin : g_bad_sref
      $error("dram_init_sref_seq: derived self-refresh limits out of range");
   end
   if (TW > 31) begin : g_bad_tw
      $error("dram_init_sref_seq: interval counter too wide");
   end

   seq_state_t state, state_nxt, exit_state;
   logic [TW-1:0] tmr_val, exit_val;
   logic tmr_load, tmr_exp;
   logic ref_pend, ref_clr;
   logic ent_pend, ent_clr, ent_ok;
   logic ext_pend, ext_clr, ext_ok;
   logic init_tick, init_last;
   logic in_sref;
   pins_t pins_d;

   // interval timer shared by every phase; reset value covers the power-up pause
   seq_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   wake_counter #(.N(INIT_CYCLES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (init_tick),
      .last  (init_last),
      .done  (init_done)
   );

   assign in_sref = (state inside {ST_SR_CAS, ST_SR_HOLD, ST_SR_WAIT, ST_SR_LEAD, ST_SR_PRE});
   assign ent_ok  = init_done & ~in_sref;
   assign ext_ok  = (state inside {ST_SR_CAS, ST_SR_HOLD, ST_SR_WAIT});

   req_latch #(.CLEAR_WINS(1'b0)) u_ref_hold (
      .clk (clk), .rst_n (rst_n), .set (ref_req), .accept (1'b1),
      .clr (ref_clr), .pending (ref_pend)
   );

   req_latch #(.CLEAR_WINS(1'b0)) u_ent_hold (
      .clk (clk), .rst_n (rst_n), .set (sref_enter), .accept (ent_ok),
      .clr (ent_clr), .pending (ent_pend)
   );

   req_latch #(.CLEAR_WINS(1'b0)) u_ext_hold (
      .clk (clk), .rst_n (rst_n), .set (sref_exit), .accept (ext_ok),
      .clr (ext_clr), .pending (ext_pend)
   );

   // exit path: skip the early column release when the clock is too slow for it
   if (LEAD_CYC == 0) begin : g_no_lead
      assign exit_state = ST_SR_PRE;
      assign exit_val   = LD_SRPS;
   end else begin : g_lead
      assign exit_state = ST_SR_LEAD;
      assign exit_val   = LD_LEAD;
   end

   always_comb begin
      state_nxt = state;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      ref_clr   = 1'b0;
      ent_clr   = 1'b0;
      ext_clr   = 1'b0;
      init_tick = 1'b0;
      case (state)
         ST_PAUSE: if (tmr_exp) begin
            state_nxt = ST_CBR_CAS;
            tmr_load  = 1'b1;
            tmr_val   = LD_CSR;
         end
         ST_CBR_CAS: if (tmr_exp) begin
            state_nxt = ST_CBR_RAS;
            tmr_load  = 1'b1;
            tmr_val   = LD_RAS;
         end
         ST_CBR_RAS: if (tmr_exp) begin
            state_nxt = ST_CBR_PRE;
            tmr_load  = 1'b1;
            tmr_val   = LD_RP;
         end
         ST_CBR_PRE: if (tmr_exp) begin
            if (!init_done) begin
               init_tick = 1'b1;
               if (init_last) begin
                  state_nxt = ST_IDLE;
               end else begin
                  state_nxt = ST_CBR_CAS;
                  tmr_load  = 1'b1;
                  tmr_val   = LD_CSR;
               end
            end else begin
               state_nxt = ST_IDLE;
            end
         end
         ST_IDLE: begin
            if (ref_pend) begin
               state_nxt = ST_CBR_CAS;
               tmr_load  = 1'b1;
               tmr_val   = LD_CSR;
               ref_clr   = 1'b1;
            end else if (ent_pend) begin
               state_nxt = ST_SR_CAS;
               tmr_load  = 1'b1;
               tmr_val   = LD_CSR;
               ent_clr   = 1'b1;
            end
         end
         ST_SR_CAS: if (tmr_exp) begin
            state_nxt = ST_SR_HOLD;
            tmr_load  = 1'b1;
            tmr_val   = LD_SRAS;
         end
         ST_SR_HOLD: if (tmr_exp) begin
            if (ext_pend) begin
               state_nxt = exit_state;
               tmr_load  = 1'b1;
               tmr_val   = exit_val;
               ext_clr   = 1'b1;
            end else begin
               state_nxt = ST_SR_WAIT;
            end
         end
         ST_SR_WAIT: if (ext_pend) begin
            state_nxt = exit_state;
            tmr_load  = 1'b1;
            tmr_val   = exit_val;
            ext_clr   = 1'b1;
         end
         ST_SR_LEAD: if (tmr_exp) begin
            state_nxt = ST_SR_PRE;
            tmr_load  = 1'b1;
            tmr_val   = LD_SRPS;
         end
         ST_SR_PRE: if (tmr_exp) begin
            state_nxt = ST_IDLE;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   // strobes are registered from the next state so they change glitch-free at the edge
   assign pins_d = pins_of(state_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_PAUSE;
         row_strobe_n <= 1'b1;
         col_strobe_n <= 1'b1;
         busy         <= 1'b1;
      end else begin
         state        <= state_nxt;
         row_strobe_n <= pins_d.row_n;
         col_strobe_n <= pins_d.col_n;
         busy         <= pins_d.busy;
      end
   end

   // ---------------------------------------------------------------
   // checker state: run-length counters observed at the pins
   // ---------------------------------------------------------------
   logic [TW-1:0] since_rst, lo_run, lead_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
         lo_run    <= '0;
         lead_run  <= '0;
      end else begin
         if (since_rst != TW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
         if (row_strobe_n)          lo_run <= '0;
         else if (lo_run != '1)     lo_run <= lo_run + 1'b1;
         if (row_strobe_n)                        lead_run <= '0;
         else if (col_strobe_n && lead_run != '1) lead_run <= lead_run + 1'b1;
      end
   end

   // R2: no strobe activity inside the power-up pause
   p_quiet_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < TW'(PAUSE_CYC)) |-> (row_strobe_n && col_strobe_n));

   // R4, R8: the column strobe is already low when the row strobe falls
   p_col_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(row_strobe_n) |-> (!col_strobe_n && !$past(col_strobe_n)));

   // R8: a row-low run is either a refresh pulse or a full self-refresh minimum
   p_sref_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(row_strobe_n) |-> (lo_run == TW'(RAS_CYC) || lo_run >= TW'(SRAS_CYC)));

   // R10: early column release at exit never exceeds the allowed lead
   p_exit_lead_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(row_strobe_n) && lead_run != '0) |-> (lead_run == TW'(LEAD_CYC)));

   // R5: idle means both strobes are released
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (row_strobe_n && col_strobe_n));

   // R5: busy covers the whole power-up phase
   p_init_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> busy);

endmodule

// File: tb/dram_init_sref_seq_tb.sv
module dram_init_sref_seq_tb;

   localparam int T_CLK      = 20;
   localparam int PAUSE_EXP  = (200_000 + T_CLK - 1) / T_CLK;
   localparam int SRAS_EXP   = (100_000 + T_CLK - 1) / T_CLK;
   localparam int SRPS_EXP   = (90 + T_CLK - 1) / T_CLK;
   localparam int LEAD_EXP   = 50 / T_CLK;
   localparam int INIT_EXP   = 8;
   localparam int CSR_EXP    = 1;
   localparam int RAS_EXP    = 4;
   localparam int RP_EXP     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_req = 1'b0;
   logic sref_enter = 1'b0;
   logic sref_exit = 1'b0;
   logic row_strobe_n, col_strobe_n, busy, init_done;

   int checks = 0;
   int errors = 0;

   always #(T_CLK / 2) clk = ~clk;

   dram_init_sref_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_req      (ref_req),
      .sref_enter   (sref_enter),
      .sref_exit    (sref_exit),
      .row_strobe_n (row_strobe_n),
      .col_strobe_n (col_strobe_n),
      .busy         (busy),
      .init_done    (init_done)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // waits for the next refresh cycle and measures its three phases
   task automatic observe_cbr(output int lead, output int rasw, output int prew,
                              output int busy_bad);
      lead = 0; rasw = 0; prew = 0; busy_bad = 0;
      while (col_strobe_n) step();
      while (row_strobe_n && !col_strobe_n) begin
         lead++; if (!busy) busy_bad++; step();
      end
      while (!row_strobe_n) begin
         rasw++; if (!busy) busy_bad++; step();
      end
      while (busy && row_strobe_n && col_strobe_n) begin
         prew++; step();
      end
   endtask

   task automatic t_reset();
      step(); step(); step();
      chk(row_strobe_n && col_strobe_n, "R1 strobes high in reset",
          {row_strobe_n, col_strobe_n}, 3);
      chk(busy === 1'b1, "R1 busy in reset", busy, 1);
      chk(init_done === 1'b0, "R1 init_done in reset", init_done, 0);
   endtask

   task automatic t_powerup();
      int n, bad_busy, lead, rasw, prew, bb, bad_phase;
      n = 0; bad_busy = 0; bad_phase = 0;
      rst_n = 1'b1;
      do begin
         if (n == 100) begin ref_req = 1'b1; sref_enter = 1'b1; end
         step();
         n++;
         ref_req = 1'b0; sref_enter = 1'b0;
         if (!busy) bad_busy++;
      end while (row_strobe_n && col_strobe_n);
      chk(n == PAUSE_EXP, "R2 pause length", n, PAUSE_EXP);
      chk(row_strobe_n && !col_strobe_n, "R4 column before row at first wake cycle",
          {row_strobe_n, col_strobe_n}, 2);
      for (int k = 0; k < INIT_EXP; k++) begin
         if (k == INIT_EXP - 1)
            chk(init_done === 1'b0, "R3 init_done low before last wake cycle", init_done, 0);
         observe_cbr(lead, rasw, prew, bb);
         if (lead != CSR_EXP || rasw != RAS_EXP || prew != RP_EXP) bad_phase++;
         bad_busy += bb;
      end
      chk(bad_phase == 0, "R4 wake cycle phase lengths", bad_phase, 0);
      chk(init_done === 1'b1, "R3 init_done after eight wake cycles", init_done, 1);
      chk(bad_busy == 0, "R5 busy through power-up", bad_busy, 0);
   endtask

   task automatic t_held_after_init();
      int lead, rasw, prew, bb, lows;
      observe_cbr(lead, rasw, prew, bb);
      chk(rasw == RAS_EXP, "R6 refresh held over power-up", rasw, RAS_EXP);
      lows = 0;
      for (int k = 0; k < 60; k++) begin
         if (!row_strobe_n) lows++;
         step();
      end
      chk(lows == 0, "R7 early entry request dropped", lows, 0);
      chk(busy === 1'b0, "R5 idle after power-up", busy, 0);
   endtask

   task automatic t_refresh();
      int lead, rasw, prew, bb;
      ref_req = 1'b1; step(); ref_req = 1'b0;
      observe_cbr(lead, rasw, prew, bb);
      chk(lead == CSR_EXP, "R4 column lead in refresh", lead, CSR_EXP);
      chk(rasw == RAS_EXP, "R4 row low in refresh", rasw, RAS_EXP);
      chk(prew == RP_EXP, "R4 precharge after refresh", prew, RP_EXP);
      chk(bb == 0, "R5 busy during refresh", bb, 0);
   endtask

   task automatic t_priority();
      int lead, rasw, prew, bb;
      ref_req = 1'b1; sref_enter = 1'b1; step();
      ref_req = 1'b0; sref_enter = 1'b0;
      observe_cbr(lead, rasw, prew, bb);
      chk(rasw == RAS_EXP, "R12 refresh served before self-refresh", rasw, RAS_EXP);
      while (row_strobe_n) step();
      chk(busy && !col_strobe_n, "R12 self-refresh follows", {busy, col_strobe_n}, 2);
      sref_exit = 1'b1; step(); sref_exit = 1'b0;
      while (busy) step();
   endtask

   task automatic t_sref_early_exit();
      int lead, low, ld, bb, gap, rasw, prew, bb2;
      sref_enter = 1'b1; step(); sref_enter = 1'b0;
      lead = 0;
      while (col_strobe_n) step();
      while (row_strobe_n && !col_strobe_n) begin lead++; step(); end
      chk(lead == CSR_EXP, "R8 column lead at entry", lead, CSR_EXP);
      low = 0; ld = 0; bb = 0;
      while (!row_strobe_n) begin
         low++;
         if (col_strobe_n) ld++;
         if (!busy) bb++;
         if (low == 1) begin sref_exit = 1'b1; ref_req = 1'b1; end
         step();
         sref_exit = 1'b0; ref_req = 1'b0;
      end
      chk(low >= SRAS_EXP, "R8 row low minimum", low, SRAS_EXP);
      chk(low == SRAS_EXP + LEAD_EXP, "R9 early exit held to minimum", low, SRAS_EXP + LEAD_EXP);
      chk(ld == LEAD_EXP, "R10 column release lead", ld, LEAD_EXP);
      chk(bb == 0, "R5 busy in self-refresh", bb, 0);
      gap = 0;
      while (row_strobe_n && col_strobe_n) begin gap++; step(); end
      chk(gap >= SRPS_EXP, "R11 precharge after exit", gap, SRPS_EXP);
      chk(gap == SRPS_EXP + 1, "R11 next cycle timing", gap, SRPS_EXP + 1);
      observe_cbr(rasw, rasw, prew, bb2);
      chk(rasw == RAS_EXP, "R6 refresh held over self-refresh", rasw, RAS_EXP);
   endtask

   task automatic t_sref_late_exit();
      int bad, ld, lows;
      sref_exit = 1'b1; step(); sref_exit = 1'b0;
      repeat (5) step();
      sref_enter = 1'b1; step(); sref_enter = 1'b0;
      while (row_strobe_n) step();
      bad = 0;
      for (int k = 0; k < SRAS_EXP + 200; k++) begin
         if (row_strobe_n || col_strobe_n || !busy) bad++;
         if (k == 10) sref_enter = 1'b1;
         step();
         sref_enter = 1'b0;
      end
      chk(bad == 0, "R9 session holds without exit; idle exit ignored", bad, 0);
      sref_exit = 1'b1; step(); sref_exit = 1'b0;
      ld = 0;
      while (!row_strobe_n) begin
         if (col_strobe_n) ld++;
         step();
      end
      chk(ld == LEAD_EXP, "R10 column release lead after late exit", ld, LEAD_EXP);
      lows = 0;
      for (int k = 0; k < 100; k++) begin
         if (!row_strobe_n || !col_strobe_n) lows++;
         step();
      end
      chk(lows == 0, "R7 entry request during session dropped", lows, 0);
      chk(busy === 1'b0, "R5 idle after session", busy, 0);
   endtask

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      t_reset();
      t_powerup();
      t_held_after_init();
      t_refresh();
      t_priority();
      t_sref_early_exit();
      t_sref_late_exit();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule